// File: doc/BRIEF.md
# Constant Off-Time Bridge Current Chopper

This block regulates the peak current in one motor winding by chopping the four gates of its H-bridge. While enabled it drives the bridge in the direction given by a polarity input. When a synchronized comparator input reports that the winding current has passed its limit, the block starts an off interval of fixed length and then drives again. One instance serves each bridge, and every instance runs on its own.

Each drive interval starts with a blanking window. During this window the comparator is masked, so the switching spike at turn-on cannot end the drive early. An off interval starts only on a rising edge of the masked comparator signal. The off interval starts with a dead time in which all four switches are off. For the rest of the off interval, the decay-mode input picks the pattern. In slow decay both high-side switches are on. In fast decay all four switches stay off. The off length is a cycle count that is sampled when the off interval starts. The blanking and dead lengths are parameters. When the enable input is low, all gates go off at once and the internal timing is cleared.

Top module: `pwm_chopper`

## Requirements
- R1: While `enable` is low, or during reset, all four gate outputs are low. They go low in the same cycle that `enable` falls.
- R2: In the drive phase, `fwd`=1 turns on `hi_a` and `lo_b`, and `fwd`=0 turns on `hi_b` and `lo_a`. The other two gates stay low.
- R3: A drive phase lasts at least BLANK_CYC+1 cycles. A comparator high seen in the first BLANK_CYC drive cycles does not end it.
- R4: If the comparator is high in a drive cycle after blanking and was not high in the cycle before, the bridge leaves drive in the next cycle.
- R5: If the comparator stays high across a whole off interval, the next drive phase ends after exactly BLANK_CYC+1 cycles.
- R6: The first DEAD_CYC cycles of every off interval have all four gates low.
- R7: An off interval lasts max(`toff_cycles`, DEAD_CYC) cycles. `toff_cycles` is sampled in the cycle that ends drive. Drive then resumes.
- R8: With `fast_decay`=0, each off cycle after the dead time has `hi_a` and `hi_b` high and both low-side gates low.
- R9: With `fast_decay`=1, all four gates stay low for the whole off interval.
- R10: After `enable` rises, the gates stay low for one cycle. Drive then starts with a fresh blanking window.
- R11: No leg ever has its high-side and low-side gates on in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Bridge allowed to conduct (sequencer and protection) |
| fwd | input | 1 | Drive polarity: 1 = A high / B low, 0 = B high / A low |
| sense_hi | input | 1 | Synchronized comparator: winding current above limit |
| fast_decay | input | 1 | 1 = all switches off while recirculating, 0 = both high sides on |
| toff_cycles | input | TOFF_W | Off interval length in clock cycles |
| hi_a | output | 1 | Gate of leg A high-side switch |
| lo_a | output | 1 | Gate of leg A low-side switch |
| hi_b | output | 1 | Gate of leg B high-side switch |
| lo_b | output | 1 | Gate of leg B low-side switch |

## Verification
The hardest situation to reach is a comparator rise that falls inside the blanking window. To see that it was ignored, the current must drop again before blanking ends, and the bridge must be shown to stay in drive long afterwards. The stimulus re-enables the bridge so that the start of drive is known to the cycle. It then pulses `sense_hi` for a single cycle inside the window and watches the drive pattern hold for ten more cycles before it raises the comparator for real. Holding the comparator high across whole off intervals reaches the forced-trip case at the end of blanking without a new edge at the ports.

// File: rtl/pwm_chop_pkg.sv
package pwm_chop_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DRIVE  = 2'd1,
    PH_DEAD   = 2'd2,
    PH_RECIRC = 2'd3
  } phase_t;

  typedef struct packed {
    logic hi_a;
    logic lo_a;
    logic hi_b;
    logic lo_b;
  } bridge_gates_t;

  // Gate pattern for a phase; decay mode only matters while recirculating
  function automatic bridge_gates_t gates_for(input phase_t ph, input logic fwd,
                                              input logic fast);
    bridge_gates_t g;
    g = '0;
    case (ph)
      PH_DRIVE: begin
        g.hi_a = fwd;
        g.lo_b = fwd;
        g.hi_b = !fwd;
        g.lo_a = !fwd;
      end
      PH_RECIRC: begin
        g.hi_a = !fast;
        g.hi_b = !fast;
      end
      default: g = '0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/chop_blank_edge.sv
module chop_blank_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sense_i,
  input  logic window_i,
  output logic trip_o
);
  logic masked;
  logic masked_q;

  assign masked = sense_i & window_i;
  assign trip_o = masked & ~masked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) masked_q <= 1'b0;
    else        masked_q <= masked;
  end

  // R4: a trip never repeats in back-to-back cycles
  a_r4_single_trip: assert property (@(posedge clk) disable iff (!rst_n)
    trip_o |=> !trip_o);
endmodule

// File: rtl/chop_phase_fsm.sv
module chop_phase_fsm
  import pwm_chop_pkg::*;
#(
  parameter int TOFF_W    = 10,
  parameter int BLANK_CYC = 16,
  parameter int DEAD_CYC  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              trip_i,
  input  logic [TOFF_W-1:0] toff_i,
  output phase_t            phase_o,
  output logic              window_o
);
  localparam int CNT_W = TOFF_W;
  localparam logic [CNT_W-1:0] BLANK_V = CNT_W'(BLANK_CYC);
  localparam logic [CNT_W-1:0] DEAD_V  = CNT_W'(DEAD_CYC);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] span;

  // Off length never shorter than the dead time
  function automatic logic [CNT_W-1:0] off_span(input logic [CNT_W-1:0] req);
    return (req < DEAD_V) ? DEAD_V : req;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      span  <= DEAD_V;
    end else if (!enable_i) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          phase <= PH_DRIVE;
          cnt   <= '0;
        end
        PH_DRIVE: begin
          if (trip_i) begin
            phase <= PH_DEAD;
            cnt   <= '0;
            span  <= off_span(toff_i);
          end else if (cnt < BLANK_V) begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DEAD: begin
          if (cnt == span - 1'b1) begin
            phase <= PH_DRIVE;
            cnt   <= '0;
          end else begin
            if (cnt == DEAD_V - 1'b1) phase <= PH_RECIRC;
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == span - 1'b1) begin
            phase <= PH_DRIVE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign phase_o  = phase;
  assign window_o = (phase == PH_DRIVE) && (cnt == BLANK_V);

  // R3: blanking cycles cannot leave drive except through disable
  a_r3_blank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DRIVE && cnt < BLANK_V) |=> (phase == PH_DRIVE || phase == PH_IDLE));
  // R4: a trip from the edge detector always opens an off interval
  a_r4_trip_to_dead: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DRIVE && trip_i && enable_i) |=> (phase == PH_DEAD));
  // R10: an enabled idle phase always moves to drive
  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && enable_i) |=> (phase == PH_DRIVE));
endmodule

// File: rtl/chop_gate_map.sv
module chop_gate_map
  import pwm_chop_pkg::*;
(
  input  logic          enable_i,
  input  phase_t        phase_i,
  input  logic          fwd_i,
  input  logic          fast_i,
  output bridge_gates_t gates_o
);
  always_comb begin
    if (enable_i) gates_o = gates_for(phase_i, fwd_i, fast_i);
    else          gates_o = '0;
  end
endmodule

// File: rtl/pwm_chopper.sv
module pwm_chopper
  import pwm_chop_pkg::*;
#(
  parameter int TOFF_W    = 10,
  parameter int BLANK_CYC = 16,
  parameter int DEAD_CYC  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              fwd,
  input  logic              sense_hi,
  input  logic              fast_decay,
  input  logic [TOFF_W-1:0] toff_cycles,
  output logic              hi_a,
  output logic              lo_a,
  output logic              hi_b,
  output logic              lo_b
);
  phase_t        phase;
  logic          window;
  logic          trip;
  bridge_gates_t gates;

  chop_blank_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sense_i  (sense_hi),
    .window_i (window),
    .trip_o   (trip)
  );

  chop_phase_fsm #(
    .TOFF_W    (TOFF_W),
    .BLANK_CYC (BLANK_CYC),
    .DEAD_CYC  (DEAD_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (enable),
    .trip_i   (trip),
    .toff_i   (toff_cycles),
    .phase_o  (phase),
    .window_o (window)
  );

  chop_gate_map u_map (
    .enable_i (enable),
    .phase_i  (phase),
    .fwd_i    (fwd),
    .fast_i   (fast_decay),
    .gates_o  (gates)
  );

  assign hi_a = gates.hi_a;
  assign lo_a = gates.lo_a;
  assign hi_b = gates.hi_b;
  assign lo_b = gates.lo_b;

  a_r1_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !(hi_a || lo_a || hi_b || lo_b));
  a_r6_dead_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DEAD) |-> !(hi_a || lo_a || hi_b || lo_b));
  a_r8_slow_recirc: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && phase == PH_RECIRC && !fast_decay) |-> (hi_a && hi_b && !lo_a && !lo_b));
  a_r9_fast_recirc: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RECIRC && fast_decay) |-> !(hi_a || lo_a || hi_b || lo_b));
  a_r11_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_a && lo_a) && !(hi_b && lo_b));
endmodule

// File: tb/pwm_chopper_test.sv
`timescale 1ns/1ps
module pwm_chopper_test;
  localparam int CLK_PERIOD = 10;
  localparam int TW    = 8;
  localparam int BLANK = 4;
  localparam int DEAD  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, fwd = 1'b1, sense_hi = 1'b0, fast_decay = 1'b0;
  logic [TW-1:0] toff_cycles = 8'd10;
  logic hi_a, lo_a, hi_b, lo_b;
  logic [3:0] gvec;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_chopper #(.TOFF_W(TW), .BLANK_CYC(BLANK), .DEAD_CYC(DEAD)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fwd(fwd), .sense_hi(sense_hi),
    .fast_decay(fast_decay), .toff_cycles(toff_cycles),
    .hi_a(hi_a), .lo_a(lo_a), .hi_b(hi_b), .lo_b(lo_b));

  assign gvec = {hi_a, lo_a, hi_b, lo_b};

  // Reference model: 0 idle, 1 drive, 2 off
  int  m_mode = 0, on_age = 0, off_age = 0, off_total = DEAD;
  bit  m_prev = 0;

  always @(posedge clk) begin
    if (!rst_n || !enable) begin
      m_mode = 0; m_prev = 0;
    end else if (m_mode == 0) begin
      m_mode = 1; on_age = 0; m_prev = 0;
    end else if (m_mode == 1) begin
      bit m;
      m = sense_hi && (on_age >= BLANK);
      if (m && !m_prev) begin
        m_mode = 2; off_age = 0;
        off_total = (int'(toff_cycles) < DEAD) ? DEAD : int'(toff_cycles);
      end else on_age++;
      m_prev = m;
    end else begin
      m_prev = 0;
      off_age++;
      if (off_age == off_total) begin m_mode = 1; on_age = 0; end
    end
  end

  function automatic logic [3:0] model_gates(output string req);
    if (!enable || m_mode == 0) begin req = "R1"; return 4'b0000; end
    if (m_mode == 1) begin req = "R2"; return fwd ? 4'b1001 : 4'b0110; end
    if (off_age < DEAD) begin req = "R6"; return 4'b0000; end
    if (fast_decay) begin req = "R9"; return 4'b0000; end
    req = "R8"; return 4'b1010;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      string r;
      logic [3:0] e;
      e = model_gates(r);
      check(r, gvec, e);
      check("R11", (hi_a && lo_a) || (hi_b && lo_b), 0);
    end
  end

  task automatic step_drive();
    @(posedge clk); #1;
  endtask

  task automatic run_len(input logic [3:0] pat, input bit sync, output int n);
    int guard = 0;
    n = 0;
    if (sync) @(negedge clk);
    while (gvec != pat && guard < 300) begin @(negedge clk); guard++; end
    while (gvec == pat && n < 300) begin n++; @(negedge clk); end
  endtask

  task automatic restart();
    step_drive(); enable = 1'b0;
    step_drive(); step_drive(); enable = 1'b1;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 reset", gvec, 4'b0000);
    step_drive(); rst_n = 1'b1;

    // Slow decay, comparator held high: blanking, dead, recirc, re-trip
    fwd = 1'b1; fast_decay = 1'b0; toff_cycles = 8'd10; sense_hi = 1'b1;
    step_drive(); enable = 1'b1;
    #1 check("R10 idle after enable", gvec, 4'b0000);
    run_len(4'b1001, 1, n); check("R3 min drive", n, BLANK + 1);
    run_len(4'b0000, 0, n); check("R6 dead length", n, DEAD);
    run_len(4'b1010, 0, n); check("R8 slow recirc length", n, 10 - DEAD);
    run_len(4'b1001, 0, n); check("R5 re-trip drive length", n, BLANK + 1);

    // Fast decay: whole off interval quiet
    fast_decay = 1'b1;
    restart();
    run_len(4'b1001, 1, n); check("R10 fresh blanking", n, BLANK + 1);
    run_len(4'b0000, 0, n); check("R9 fast off length", n, 10);
    check("R7 drive resumes", gvec, 4'b1001);

    // Short off request clamps to the dead time
    fast_decay = 1'b0; toff_cycles = 8'd1;
    restart();
    run_len(4'b1001, 1, n); check("R3 drive length short toff", n, BLANK + 1);
    run_len(4'b0000, 0, n); check("R7 clamp to dead", n, DEAD);
    run_len(4'b1001, 0, n); check("R7 no recirc when clamped", n, BLANK + 1);

    // Blanking ignores a pulse; later rise trips (reverse polarity)
    toff_cycles = 8'd6; fwd = 1'b0; sense_hi = 1'b0;
    restart();
    step_drive(); sense_hi = 1'b1;
    step_drive(); sense_hi = 1'b0;
    repeat (10) step_drive();
    check("R3 pulse in blanking ignored", gvec, 4'b0110);
    step_drive(); sense_hi = 1'b1;
    @(negedge clk); check("R4 still driving in sample cycle", gvec, 4'b0110);
    @(negedge clk); check("R4 off after rise", gvec, 4'b0000);
    sense_hi = 1'b0;

    // Disable mid-drive: gates drop at once
    repeat (12) step_drive();
    check("R2 reverse drive", gvec, 4'b0110);
    step_drive(); enable = 1'b0;
    #1 check("R1 immediate off", gvec, 4'b0000);
    repeat (3) step_drive();
    check("R1 stays off", gvec, 4'b0000);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule